// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the slave-side protocol engine of a two-wire serial memory. It watches already-synchronized, oversampled copies of the serial clock and data lines, recognises start and stop conditions and collects bytes most significant bit first. It answers only to a device-address byte whose upper part is the fixed memory type code and whose lower part matches three strap inputs. It pulls the data line low through a drive-low enable for acknowledges and for read data.

The address counter, the storage array and the write-cycle timer live outside. The block loads the counter from a two-byte word address. It asks for an increment after every byte written or sent, and flags whether that increment must stay inside the current 32-byte page. It issues one byte write request per received data byte and pulses a start request for the timed write cycle when a stop closes a write that carried data. While the timer reports busy, the block ignores traffic and leaves its device address unacknowledged, so a master can poll for completion.

Top module: `twm_slave`

## Requirements
- R1: A start (data falling while clock high) from any state begins a new device-address byte; a stop (data rising while clock high) returns the block to idle with the data line released.
- R2: The device-address byte is acknowledged only when its upper seven bits equal binary 1010 followed by `strap_i[2:0]`; bit 0 is read (1) or write (0). On a mismatch the data line stays released until the next start, and no memory request is made.
- R3: In a write, the two bytes after the device address are each acknowledged; the counter is loaded with address {first[4:0], second}, the top three bits of the first byte being ignored.
- R4: Every data byte of a write is acknowledged and produces one write request carrying that byte, together with an increment flagged to wrap inside the 32-byte page.
- R5: Page writes longer than the remainder of a page continue at the start of the same page.
- R6: A stop after at least one complete data byte produces exactly one write-cycle start pulse; a stop after a header only, or after a partial data byte, produces none.
- R7: While the write cycle is busy the device-address byte is not acknowledged and no request is made; once idle it is acknowledged again.
- R8: Read data leaves most significant bit first; the data line changes only while the clock is low; after each byte the counter is incremented linearly (crossing the end of memory to address 0), and the next byte follows when the master acknowledges.
- R9: A master NACK after a read byte ends the read: the data line stays released for all further clocks until a start.
- R10: A random read (write header, repeated start, read address) returns data at the loaded address and starts no write cycle.
- R11: A start or stop in the middle of a byte abandons it and realigns bit counting to the next byte.
- R12: After reset the data line is released and no request or pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized resolved serial data |
| strap_i | input | 3 | Device select straps |
| sda_drive_o | output | 1 | 1 pulls the data line low |
| wc_busy_i | input | 1 | External write cycle in progress |
| wc_start_o | output | 1 | One-cycle request to begin the write cycle |
| ac_load_o | output | 1 | Load the address counter |
| ac_load_addr_o | output | 13 | Value for the counter load |
| ac_inc_o | output | 1 | Increment the address counter |
| ac_wrap_page_o | output | 1 | With ac_inc_o: wrap inside the 32-byte page |
| mem_rdata_i | input | 8 | Array data at the counter address |
| mem_wr_o | output | 1 | Write request at the counter address |
| mem_wdata_o | output | 8 | Data for the write request |

## Verification
A wrong bit count or phase shows up at the ninth clock of the very byte it hits, as a missing or misplaced acknowledge or as read data shifted by one bit. A wrong state after the device address appears within the following byte as a wrong counter load, a spurious write request or data from the wrong location. An error in the busy or stop handling surfaces only at the next transaction, as an acknowledge while polling or a missing write-cycle pulse, so every write is followed by polling and a read-back.

// File: rtl/twm_pkg.sv
// Shared types and constants of the two-wire memory slave.
package twm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_WAH, ST_WAL, ST_WDAT, ST_RD
    } twm_state_e;
    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twm_cond.sv
// Line event detector: finds clock edges and start/stop conditions.
// Assumes inputs are already synchronized; lines idle high after reset.
module twm_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // hold the previous line levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // decode events from previous and present levels
    always_comb begin
        scl_rise  = scl_i & ~scl_q;
        scl_fall  = ~scl_i & scl_q;
        start_det = scl_i & scl_q & sda_q & ~sda_i;
        stop_det  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/twm_shreg.sv
// Left-shifting byte register with parallel load; used for receive and transmit.
// Assumes load and shift are never requested together (load wins).
module twm_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);
    // load or shift one bit in from the right
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_o <= '0;
        else if (load)
            data_o <= load_data;
        else if (shift)
            data_o <= {data_o[W-2:0], bit_i};
    end
endmodule

// File: rtl/twm_slave.sv
// Two-wire serial memory slave protocol engine.
// Sequences device address, two-byte word address, write data and read data.
// Assumes an external address counter (load/increment), a combinational read
// port at the counter address and an external write-cycle timer (busy).
module twm_slave #(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter int STRAP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic              sda_drive_o,
    input  logic              wc_busy_i,
    output logic              wc_start_o,
    output logic              ac_load_o,
    output logic [ADDR_W-1:0] ac_load_addr_o,
    output logic              ac_inc_o,
    output logic              ac_wrap_page_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_wr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);
    import twm_pkg::*;

    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int CNT_W  = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(DATA_W + 1);

    twm_state_e        state_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic              ack_q, rw_q, wrote_q;
    logic [HI_W-1:0]   hi_q;
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic [DATA_W-1:0] rx_byte, tx_byte, rx_next;
    logic              receiving, addr_hit, rx_shift, tx_load, tx_shift;

    twm_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twm_shreg #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .load_data('0),
        .shift(rx_shift), .bit_i(sda_i), .data_o(rx_byte)
    );

    twm_shreg #(.W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .load_data(mem_rdata_i),
        .shift(tx_shift), .bit_i(1'b0), .data_o(tx_byte)
    );

    // byte assembly, address match and shift-register control
    always_comb begin
        receiving = (state_q == ST_DEV) || (state_q == ST_WAH) ||
                    (state_q == ST_WAL) || (state_q == ST_WDAT);
        rx_next   = {rx_byte[DATA_W-2:0], sda_i};
        addr_hit  = (rx_next[DATA_W-1:1] == {DEV_TYPE, strap_i}) && !wc_busy_i;
        rx_shift  = receiving && scl_rise && (bitcnt_q < ACK_SLOT);
        tx_load   = scl_fall && (bitcnt_q == ACK_DONE) &&
                    ((state_q == ST_RD) || (state_q == ST_DEV && rw_q));
        tx_shift  = (state_q == ST_RD) && scl_fall &&
                    (bitcnt_q != '0) && (bitcnt_q < ACK_SLOT);
    end

    // transaction sequencer, line drive and request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;  bitcnt_q <= '0;  ack_q <= 1'b0;
            rw_q <= 1'b0;  wrote_q <= 1'b0;  hi_q <= '0;
            sda_drive_o <= 1'b0;  wc_start_o <= 1'b0;  ac_load_o <= 1'b0;
            ac_load_addr_o <= '0;  ac_inc_o <= 1'b0;  ac_wrap_page_o <= 1'b0;
            mem_wr_o <= 1'b0;  mem_wdata_o <= '0;
        end else begin
            wc_start_o <= 1'b0;  ac_load_o <= 1'b0;
            ac_inc_o <= 1'b0;  mem_wr_o <= 1'b0;
            if (start_det) begin
                state_q <= ST_DEV;  bitcnt_q <= '0;  ack_q <= 1'b0;
                sda_drive_o <= 1'b0;  wrote_q <= 1'b0;
            end else if (stop_det) begin
                state_q <= ST_IDLE;  sda_drive_o <= 1'b0;
                wc_start_o <= wrote_q;  wrote_q <= 1'b0;
            end else if (receiving) begin
                if (scl_rise && bitcnt_q < ACK_SLOT) begin
                    bitcnt_q <= bitcnt_q + 1'b1;
                    if (bitcnt_q == LAST_BIT) begin
                        ack_q <= 1'b1;
                        case (state_q)
                            ST_DEV: begin
                                rw_q <= rx_next[0];
                                if (!addr_hit) begin
                                    state_q <= ST_IDLE;
                                    ack_q   <= 1'b0;
                                end
                            end
                            ST_WAH: hi_q <= rx_next[HI_W-1:0];
                            ST_WAL: begin
                                ac_load_o      <= 1'b1;
                                ac_load_addr_o <= {hi_q, rx_next};
                            end
                            default: begin
                                mem_wr_o <= 1'b1;  mem_wdata_o <= rx_next;
                                ac_inc_o <= 1'b1;  ac_wrap_page_o <= 1'b1;
                                wrote_q  <= 1'b1;
                            end
                        endcase
                    end
                end else if (scl_rise) begin
                    bitcnt_q <= ACK_DONE;
                end
                if (scl_fall && bitcnt_q == ACK_SLOT)
                    sda_drive_o <= ack_q;
                if (scl_fall && bitcnt_q == ACK_DONE) begin
                    bitcnt_q <= '0;  ack_q <= 1'b0;  sda_drive_o <= 1'b0;
                    case (state_q)
                        ST_DEV: begin
                            state_q <= rw_q ? ST_RD : ST_WAH;
                            if (rw_q) sda_drive_o <= ~mem_rdata_i[DATA_W-1];
                        end
                        ST_WAH:  state_q <= ST_WAL;
                        default: state_q <= ST_WDAT;
                    endcase
                end
            end else if (state_q == ST_RD) begin
                if (scl_rise && bitcnt_q < ACK_SLOT) begin
                    bitcnt_q <= bitcnt_q + 1'b1;
                end else if (scl_rise && bitcnt_q == ACK_SLOT) begin
                    ac_inc_o <= 1'b1;  ac_wrap_page_o <= 1'b0;
                    if (sda_i) state_q <= ST_IDLE;
                    else bitcnt_q <= ACK_DONE;
                end
                if (tx_shift)
                    sda_drive_o <= ~tx_byte[DATA_W-2];
                if (scl_fall && bitcnt_q == ACK_SLOT)
                    sda_drive_o <= 1'b0;
                if (scl_fall && bitcnt_q == ACK_DONE) begin
                    bitcnt_q <= '0;
                    sda_drive_o <= ~mem_rdata_i[DATA_W-1];
                end
            end
        end
    end

    // R8
    drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && !scl_rise) |=> $stable(sda_drive_o));
    // R4
    wr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (ac_inc_o && ac_wrap_page_o));
    // R12
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ac_load_o, mem_wr_o, wc_start_o}));
    // R8
    inc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ac_inc_o |=> !ac_inc_o);
    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wc_busy_i |-> (!mem_wr_o && !ac_load_o));
endmodule

// File: tb/twm_slave_tb.sv
// Bench: behavioural master, external counter/array/timer, and a reference
// memory model; bit values compared at every clock-high sample, line
// release and drive stability compared on every system clock.
module twm_slave_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic sda_drive, wc_busy, wc_start, ac_load, ac_inc, ac_wrap, mem_wr;
    logic [12:0] ac_addr;
    logic [7:0] mem_rdata, mem_wdata;
    logic sda_line;

    logic [7:0]  ext_mem [8192];
    logic [12:0] ext_ptr;
    int busy_cnt = 0;
    logic [7:0]  model_mem [8192];
    int model_ptr = 0;
    int checks = 0, errors = 0;
    int wc_cnt = 0, wr_cnt = 0, wr_nowrap = 0, stab_err = 0, rel_err = 0;
    bit exp_release = 1'b0;
    logic prev_scl = 1'b1, prev_drv = 1'b0;

    always #5 clk = ~clk;
    assign sda_line  = sda_m & ~sda_drive;
    assign mem_rdata = ext_mem[ext_ptr];
    assign wc_busy   = (busy_cnt != 0);

    twm_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
        .sda_drive_o(sda_drive), .wc_busy_i(wc_busy), .wc_start_o(wc_start),
        .ac_load_o(ac_load), .ac_load_addr_o(ac_addr), .ac_inc_o(ac_inc),
        .ac_wrap_page_o(ac_wrap), .mem_rdata_i(mem_rdata), .mem_wr_o(mem_wr),
        .mem_wdata_o(mem_wdata)
    );

    // external address counter, array and write-cycle timer
    always_ff @(posedge clk) begin
        if (ac_load) ext_ptr <= ac_addr;
        else if (ac_inc) ext_ptr <= ac_wrap ? {ext_ptr[12:5], ext_ptr[4:0] + 5'd1}
                                            : ext_ptr + 13'd1;
        if (mem_wr) ext_mem[ext_ptr] <= mem_wdata;
        if (wc_start) busy_cnt <= 400;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end

    // per-clock monitors, sampled after the edge settles
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (wc_start) wc_cnt++;
            if (mem_wr) begin wr_cnt++; if (!ac_wrap) wr_nowrap++; end
            if (prev_scl && scl && sda_drive != prev_drv) stab_err++;
            if (exp_release && sda_drive) rel_err++;
        end
        prev_scl = scl;
        prev_drv = sda_drive;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk(input bit b, output bit l);
        wt(2); sda_m = b; wt(2); scl = 1'b1; wt(2); l = sda_line; wt(2); scl = 1'b0;
    endtask

    task automatic do_start();
        wt(1); sda_m = 1'b1; wt(2); scl = 1'b1; wt(2); sda_m = 1'b0; wt(2); scl = 1'b0;
    endtask

    task automatic do_stop();
        wt(2); sda_m = 1'b0; wt(2); scl = 1'b1; wt(2); sda_m = 1'b1; wt(4);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit l;
        for (int i = 7; i >= 0; i--) sclk(b[i], l);
        sclk(1'b1, l);
        chk(req, int'(!l), int'(exp_ack));
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit mack, input string req);
        bit l;
        logic [7:0] got = '0;
        for (int i = 0; i < 8; i++) begin sclk(1'b1, l); got = {got[6:0], l}; end
        chk(req, got, exp);
        sclk(!mack, l);
    endtask

    task automatic header(input logic [12:0] a);
        send_byte(8'hAA, 1'b1, "R2 write address ack");
        send_byte({3'b110, a[12:8]}, 1'b1, "R3 high address ack");
        send_byte(a[7:0], 1'b1, "R3 low address ack");
        model_ptr = a;
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d [4], input int n);
        int w0 = wc_cnt;
        do_start(); header(a);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], 1'b1, "R4 data ack");
            model_mem[model_ptr] = d[k];
            model_ptr = (model_ptr & 32'h1FE0) | ((model_ptr + 1) & 32'h1F);
        end
        do_stop(); wt(2);
        chk("R6 one write cycle start", wc_cnt - w0, 1);
    endtask

    task automatic wait_ready();
        bit l;
        do_start(); send_byte(8'hAA, 1'b0, "R7 no ack while busy"); do_stop();
        for (int t = 0; t < 20; t++) begin
            do_start();
            for (int i = 7; i >= 0; i--) sclk(8'hAA >> i, l);
            sclk(1'b1, l);
            do_stop();
            if (!l) break;
        end
        chk("R7 acked after busy", int'(wc_busy), 0);
    endtask

    task automatic read_seq(input int n, input bit end_stop);
        for (int k = 0; k < n; k++) begin
            recv_byte(model_mem[model_ptr], k < n - 1, "R8 read data");
            model_ptr = (model_ptr + 1) & 32'h1FFF;
        end
        if (end_stop) do_stop();
    endtask

    task automatic rd_random(input logic [12:0] a, input int n, input bit end_stop);
        do_start(); header(a);
        do_start(); send_byte(8'hAB, 1'b1, "R10 read address ack");
        read_seq(n, end_stop);
    endtask

    initial begin
        logic [7:0] d [4];
        bit l;
        int w0, m0;
        for (int i = 0; i < 8192; i++) begin
            ext_mem[i] = 8'(i * 37 + 11);
            model_mem[i] = 8'(i * 37 + 11);
        end
        wt(4); rst_n = 1'b1; wt(2);
        chk("R12 reset drive", int'(sda_drive), 0);
        chk("R12 reset pulses", int'({wc_start, ac_load, ac_inc, mem_wr}), 0);

        d = '{8'h5A, 8'h00, 8'h00, 8'h00};
        do_write(13'h0123, d, 1);
        wait_ready();
        w0 = wc_cnt;
        rd_random(13'h0123, 1, 1'b1);
        chk("R10 no write cycle from read", wc_cnt - w0, 0);

        d = '{8'h11, 8'h22, 8'h33, 8'h44};
        do_write(13'h1FFE, d, 4);
        wait_ready();
        chk("R5 page wrap landed", int'(ext_mem[13'h1FE0]), 8'h33);
        rd_random(13'h1FFE, 3, 1'b1);
        do_start(); send_byte(8'hAB, 1'b1, "R8 current address ack");
        read_seq(1, 1'b1);

        w0 = wr_cnt;
        do_start(); exp_release = 1'b1;
        send_byte(8'hA2, 1'b0, "R2 mismatch not acked");
        send_byte(8'h55, 1'b0, "R2 released after mismatch");
        do_stop(); exp_release = 1'b0;
        chk("R2 no request on mismatch", wr_cnt - w0, 0);

        rd_random(13'h0200, 1, 1'b0);
        exp_release = 1'b1;
        recv_byte(8'hFF, 1'b0, "R9 released after NACK");
        exp_release = 1'b0;
        do_stop();

        do_start();
        for (int i = 7; i >= 4; i--) sclk(8'hAA >> i, l);
        d = '{8'h77, 8'h00, 8'h00, 8'h00};
        do_write(13'h0040, d, 1);
        wait_ready();
        rd_random(13'h0040, 1, 1'b1);
        chk("R11 resync write", int'(ext_mem[13'h0040]), 8'h77);

        w0 = wc_cnt; m0 = wr_cnt;
        do_start(); header(13'h0050);
        for (int i = 7; i >= 5; i--) sclk(1'b0, l);
        do_stop(); wt(4);
        chk("R6 no cycle on partial byte", wc_cnt - w0, 0);
        chk("R11 no write on partial byte", wr_cnt - m0, 0);
        w0 = wc_cnt;
        do_start(); send_byte(8'hAA, 1'b1, "R1 start after stop"); do_stop(); wt(4);
        chk("R6 no cycle on header only", wc_cnt - w0, 0);
        chk("R1 idle after stop", int'(sda_drive), 0);
        chk("R4 writes wrap in page", wr_nowrap, 0);
        chk("R8 drive stable while clock high", stab_err, 0);
        chk("R9 release monitor", rel_err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule